// File: doc/BRIEF.md
# Board Status Register Block

This block answers register-bus accesses from system software with a small set of read-only words. These words describe the board: memory controller health, the enabled high-speed links, clock generator settings and memory configuration. Two of the words include live configuration inputs. One is the reference clock frequency in MHz. The other is the installed memory size in GiB.

The bus is a plain 32-bit register port with no wait states. It has:
- a select strobe,
- a write flag,
- an address,
- write data,
- an access-size code.

Read data appears, registered, in the cycle after the select. Only full-word accesses are acted upon. The block also holds one write-only control location. Writing it with the reset bit set raises a one-cycle system reset request.

Top module: `board_status_regs`

## Requirements
- R1: During and straight after reset, `prdata` is zero and `rst_req_o` is low.
- R2: An access is honoured only when `psize` is 2 (four bytes). A read with any other size code (0 = one byte, 1 = two bytes, 3 = eight bytes) returns zero, and a write with any other size code does nothing.
- R3: The register is chosen by `paddr[15:0]` alone. The address bits above bit 15 do not change the result of a read or a write.
- R4: The identity words at offsets 0x00, 0x04 and 0x08 read as zero.
- R5: The memory controller status word at offset 0x14 reads as 0x00000005 (bit 0 locked, bit 2 calibrated).
- R6: The clock generator word at offset 0x30 reads as {8'd1, 8'd1, ref_mhz, 8'd1}. That is clock-1 divider in [31:24], multiplier in [23:16], reference MHz in [15:8] and clock-0 divider in [7:0].
- R7: The build options word at offset 0x34 reads as 0x0000000E: bits 3..1 (three links enabled) set, bit 0 (coherence unit) clear.
- R8: The memory configuration word at offset 0x38 reads as 0x0000FFF0 | mem_gib. Bits 15:4 are all ones and bits 3:0 hold the size in GiB.
- R9: Every other offset reads as zero. This includes the reset control location 0x10 and the link status location 0x18.
- R10: A full-word write to offset 0x10 with `pwdata[4]` set drives `rst_req_o` high for exactly the one cycle after the write.
- R11: Writes that are not such a reset write never raise `rst_req_o` and leave every read value unchanged. This covers bit 4 clear, another offset, a read-only register or a wrong size.
- R12: `prdata` carries the read result in the cycle after a selected read. It is zero in the cycle after any cycle without a selected read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Access strobe; one access per cycle it is high |
| pwrite | input | 1 | 1 = write, 0 = read |
| psize | input | 2 | Access size code: 0=1B, 1=2B, 2=4B, 3=8B |
| paddr | input | ADDR_W | Byte address; low 16 bits select the register |
| pwdata | input | 32 | Write data |
| ref_mhz | input | MHZ_W | Reference clock frequency in MHz |
| mem_gib | input | GIB_W | Installed memory size in GiB |
| prdata | output | 32 | Registered read data |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The properties treat every cycle with `psel` high as a separate, complete access. They also assume `ref_mhz` and `mem_gib` stay constant while a read of the words built from them is in flight. The bench drives all bus inputs and both configuration inputs on the falling edge only. It changes the configuration inputs only between accesses, and always leaves an idle cycle between accesses. Under that discipline each registered result can be tied to exactly one access.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    localparam int DATA_W   = 32;
    localparam int OFF_W    = 16;
    localparam int SIZE_W   = 2;
    localparam int SRST_BIT = 4;

    localparam logic [SIZE_W-1:0] SZ_WORD = 2'd2;

    localparam logic [OFF_W-1:0] OFF_ID0   = 16'h0000;
    localparam logic [OFF_W-1:0] OFF_ID1   = 16'h0004;
    localparam logic [OFF_W-1:0] OFF_ID2   = 16'h0008;
    localparam logic [OFF_W-1:0] OFF_SRST  = 16'h0010;
    localparam logic [OFF_W-1:0] OFF_MSTAT = 16'h0014;
    localparam logic [OFF_W-1:0] OFF_LSTAT = 16'h0018;
    localparam logic [OFF_W-1:0] OFF_CKGEN = 16'h0030;
    localparam logic [OFF_W-1:0] OFF_BUILD = 16'h0034;
    localparam logic [OFF_W-1:0] OFF_MCFG  = 16'h0038;

    typedef enum logic [2:0] {
        RID_NONE,
        RID_IDENT,
        RID_SRST,
        RID_MSTAT,
        RID_LSTAT,
        RID_CKGEN,
        RID_BUILD,
        RID_MCFG
    } reg_id_e;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              rst_req;
    } bsr_state_t;

endpackage

// File: rtl/bsr_decode.sv
module bsr_decode
    import bsr_pkg::*;
(
    input  logic [OFF_W-1:0] offset,
    output reg_id_e          rid
);
    always_comb begin
        unique case (offset)
            OFF_ID0, OFF_ID1, OFF_ID2: rid = RID_IDENT;
            OFF_SRST:                  rid = RID_SRST;
            OFF_MSTAT:                 rid = RID_MSTAT;
            OFF_LSTAT:                 rid = RID_LSTAT;
            OFF_CKGEN:                 rid = RID_CKGEN;
            OFF_BUILD:                 rid = RID_BUILD;
            OFF_MCFG:                  rid = RID_MCFG;
            default:                   rid = RID_NONE;
        endcase
    end
endmodule

// File: rtl/bsr_compose.sv
module bsr_compose
    import bsr_pkg::*;
#(
    parameter int MHZ_W = 8,
    parameter int GIB_W = 4
) (
    input  reg_id_e           rid,
    input  logic [MHZ_W-1:0]  ref_mhz,
    input  logic [GIB_W-1:0]  mem_gib,
    output logic [DATA_W-1:0] word
);
    localparam int MHZ_FLD = 8;
    localparam int GIB_FLD = 4;

    logic [MHZ_FLD-1:0] mhz_f;
    logic [GIB_FLD-1:0] gib_f;

    generate
        if (MHZ_W >= MHZ_FLD) begin : g_mhz_cut
            assign mhz_f = ref_mhz[MHZ_FLD-1:0];
            if (MHZ_W > MHZ_FLD) begin : g_mhz_spare
                logic unused_mhz;
                assign unused_mhz = ^ref_mhz[MHZ_W-1:MHZ_FLD];
            end
        end else begin : g_mhz_pad
            assign mhz_f = {{(MHZ_FLD-MHZ_W){1'b0}}, ref_mhz};
        end
        if (GIB_W >= GIB_FLD) begin : g_gib_cut
            assign gib_f = mem_gib[GIB_FLD-1:0];
            if (GIB_W > GIB_FLD) begin : g_gib_spare
                logic unused_gib;
                assign unused_gib = ^mem_gib[GIB_W-1:GIB_FLD];
            end
        end else begin : g_gib_pad
            assign gib_f = {{(GIB_FLD-GIB_W){1'b0}}, mem_gib};
        end
    endgenerate

    always_comb begin
        word = '0;
        unique case (rid)
            RID_MSTAT: word = 32'h0000_0005;
            RID_CKGEN: word = {8'd1, 8'd1, mhz_f, 8'd1};
            RID_BUILD: word = 32'h0000_000E;
            RID_MCFG:  word = {16'h0000, 12'hFFF, gib_f};
            default:   word = '0;
        endcase
    end
endmodule

// File: rtl/board_status_regs.sv
module board_status_regs
    import bsr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int MHZ_W  = 8,
    parameter int GIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              pwrite,
    input  logic [1:0]        psize,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    input  logic [MHZ_W-1:0]  ref_mhz,
    input  logic [GIB_W-1:0]  mem_gib,
    output logic [31:0]       prdata,
    output logic              rst_req_o
);
    reg_id_e           rid;
    logic [DATA_W-1:0] word;
    logic              acc_ok;
    bsr_state_t        st_d, st_q;
    logic              unused_bits;

    assign unused_bits = ^{paddr[ADDR_W-1:OFF_W], pwdata[DATA_W-1:SRST_BIT+1],
                           pwdata[SRST_BIT-1:0]};

    bsr_decode u_decode (
        .offset (paddr[OFF_W-1:0]),
        .rid    (rid)
    );

    bsr_compose #(.MHZ_W(MHZ_W), .GIB_W(GIB_W)) u_compose (
        .rid     (rid),
        .ref_mhz (ref_mhz),
        .mem_gib (mem_gib),
        .word    (word)
    );

    assign acc_ok = psel && (psize == SZ_WORD);

    always_comb begin
        st_d         = st_q;
        st_d.rdata   = '0;
        st_d.rst_req = 1'b0;
        if (acc_ok && !pwrite) begin
            st_d.rdata = word;
        end
        if (acc_ok && pwrite && (rid == RID_SRST) && pwdata[SRST_BIT]) begin
            st_d.rst_req = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign prdata    = st_q.rdata;
    assign rst_req_o = st_q.rst_req;
endmodule

// File: rtl/bsr_checker.sv
module bsr_checker #(
    parameter int ADDR_W = 32,
    parameter int MHZ_W  = 8,
    parameter int GIB_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              pwrite,
    input logic [1:0]        psize,
    input logic [ADDR_W-1:0] paddr,
    input logic [31:0]       pwdata,
    input logic [MHZ_W-1:0]  ref_mhz,
    input logic [GIB_W-1:0]  mem_gib,
    input logic [31:0]       prdata,
    input logic              rst_req_o
);
    logic rd_word, rst_wr;
    assign rd_word = psel && !pwrite && (psize == 2'd2);
    assign rst_wr  = psel && pwrite && (psize == 2'd2) &&
                     (paddr[15:0] == 16'h0010) && pwdata[4];

    a_r10_reset_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rst_wr |=> rst_req_o);

    a_r11_no_stray_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_wr |=> !rst_req_o);

    a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(psel && !pwrite) |=> (prdata == 32'h0));

    a_r2_bad_size_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !pwrite && psize != 2'd2) |=> (prdata == 32'h0));

    a_r5_mem_status: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_word && paddr[15:0] == 16'h0014) |=> (prdata == 32'h0000_0005));

    a_r7_build_word: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_word && paddr[15:0] == 16'h0034) |=> (prdata == 32'h0000_000E));

    a_r8_mem_cfg_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_word && paddr[15:0] == 16'h0038) |=> (prdata[31:4] == 28'h0000FFF));

    a_r4_ident_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_word && (paddr[15:0] == 16'h0000 || paddr[15:0] == 16'h0004 ||
                     paddr[15:0] == 16'h0008)) |=> (prdata == 32'h0));
endmodule

bind board_status_regs bsr_checker #(
    .ADDR_W(ADDR_W), .MHZ_W(MHZ_W), .GIB_W(GIB_W)
) u_bsr_checker (
    .clk(clk), .rst_n(rst_n), .psel(psel), .pwrite(pwrite), .psize(psize),
    .paddr(paddr), .pwdata(pwdata), .ref_mhz(ref_mhz), .mem_gib(mem_gib),
    .prdata(prdata), .rst_req_o(rst_req_o)
);

// File: tb/board_status_regs_bench.sv
`timescale 1ns/1ps
module board_status_regs_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0;
    logic        pwrite = 1'b0;
    logic [1:0]  psize = 2'd2;
    logic [31:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [7:0]  ref_mhz = 8'd100;
    logic [3:0]  mem_gib = 4'd2;
    logic [31:0] prdata;
    logic        rst_req_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    board_status_regs u_board_status_regs (
        .clk(clk), .rst_n(rst_n), .psel(psel), .pwrite(pwrite), .psize(psize),
        .paddr(paddr), .pwdata(pwdata), .ref_mhz(ref_mhz), .mem_gib(mem_gib),
        .prdata(prdata), .rst_req_o(rst_req_o)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic        wr;
        logic [1:0]  sz;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp_rd;
        logic        exp_rst;
    } vec_t;

    localparam int NV = 20;
    // ref_mhz = 100 (0x64), mem_gib = 2 throughout the table
    localparam vec_t VECS [NV] = '{
        '{8'd4,  1'b0, 2'd2, 32'h0000_0000, 32'h0, 32'h0000_0000, 1'b0}, // R4
        '{8'd4,  1'b0, 2'd2, 32'h0000_0004, 32'h0, 32'h0000_0000, 1'b0}, // R4
        '{8'd4,  1'b0, 2'd2, 32'h0000_0008, 32'h0, 32'h0000_0000, 1'b0}, // R4
        '{8'd5,  1'b0, 2'd2, 32'h0000_0014, 32'h0, 32'h0000_0005, 1'b0}, // R5
        '{8'd6,  1'b0, 2'd2, 32'h0000_0030, 32'h0, 32'h0101_6401, 1'b0}, // R6
        '{8'd7,  1'b0, 2'd2, 32'h0000_0034, 32'h0, 32'h0000_000E, 1'b0}, // R7
        '{8'd8,  1'b0, 2'd2, 32'h0000_0038, 32'h0, 32'h0000_FFF2, 1'b0}, // R8
        '{8'd9,  1'b0, 2'd2, 32'h0000_0010, 32'h0, 32'h0000_0000, 1'b0}, // R9
        '{8'd9,  1'b0, 2'd2, 32'h0000_0018, 32'h0, 32'h0000_0000, 1'b0}, // R9
        '{8'd9,  1'b0, 2'd2, 32'h0000_003C, 32'h0, 32'h0000_0000, 1'b0}, // R9
        '{8'd3,  1'b0, 2'd2, 32'hABCD_0014, 32'h0, 32'h0000_0005, 1'b0}, // R3
        '{8'd2,  1'b0, 2'd0, 32'h0000_0014, 32'h0, 32'h0000_0000, 1'b0}, // R2
        '{8'd2,  1'b0, 2'd3, 32'h0000_0034, 32'h0, 32'h0000_0000, 1'b0}, // R2
        '{8'd10, 1'b1, 2'd2, 32'h0000_0010, 32'h0000_0010, 32'h0, 1'b1}, // R10
        '{8'd11, 1'b1, 2'd2, 32'h0000_0010, 32'hFFFF_FFEF, 32'h0, 1'b0}, // R11
        '{8'd2,  1'b1, 2'd1, 32'h0000_0010, 32'h0000_0010, 32'h0, 1'b0}, // R2
        '{8'd11, 1'b1, 2'd2, 32'h0000_0014, 32'hFFFF_FFFF, 32'h0, 1'b0}, // R11
        '{8'd11, 1'b0, 2'd2, 32'h0000_0014, 32'h0, 32'h0000_0005, 1'b0}, // R11
        '{8'd11, 1'b1, 2'd2, 32'h0000_0020, 32'h0000_0010, 32'h0, 1'b0}, // R11
        '{8'd3,  1'b1, 2'd2, 32'h1234_0010, 32'h0000_0010, 32'h0, 1'b1}  // R3
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    // drive on a falling edge, sample at the next falling edge
    task automatic access(input logic wr, input logic [1:0] sz,
                          input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = wr; psize = sz; paddr = a; pwdata = d;
        @(negedge clk);
        psel = 1'b0; pwrite = 1'b0; psize = 2'd2;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset prdata", prdata, 32'h0);
        check("R1 reset rst_req", {31'h0, rst_req_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset prdata", prdata, 32'h0);
        check("R1 after reset rst_req", {31'h0, rst_req_o}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].wr, VECS[i].sz, VECS[i].addr, VECS[i].wdata);
            check($sformatf("R%0d vec %0d prdata", VECS[i].req, i), prdata, VECS[i].exp_rd);
            check($sformatf("R%0d vec %0d rst_req", VECS[i].req, i),
                  {31'h0, rst_req_o}, {31'h0, VECS[i].exp_rst});
        end

        // R10: pulse lasts exactly one cycle
        access(1'b1, 2'd2, 32'h0000_0010, 32'h0000_0010);
        check("R10 pulse high", {31'h0, rst_req_o}, 32'h1);
        @(negedge clk);
        check("R10 pulse gone", {31'h0, rst_req_o}, 32'h0);

        // R12: read result then zero in idle cycle
        access(1'b0, 2'd2, 32'h0000_0034, 32'h0);
        check("R12 read valid", prdata, 32'h0000_000E);
        @(negedge clk);
        check("R12 idle zero", prdata, 32'h0);

        // R6 / R8 with other configuration values
        @(negedge clk);
        ref_mhz = 8'd200; mem_gib = 4'd1;
        access(1'b0, 2'd2, 32'h0000_0030, 32'h0);
        check("R6 clock word 200MHz", prdata, 32'h0101_C801);
        access(1'b0, 2'd2, 32'h0000_0038, 32'h0);
        check("R8 mem cfg 1GiB", prdata, 32'h0000_FFF1);

        // R1: reset mid-stream clears outputs
        access(1'b0, 2'd2, 32'h0000_0014, 32'h0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 re-reset prdata", prdata, 32'h0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule